// File: doc/BRIEF.md
# Two-Level Epoch Redirect Controller

This block is the front-end steering logic of an in-order pipeline in which two stages can each correct a wrong next-PC guess. The decode stage fixes targets it can compute early, such as absolute jumps. The execute stage fixes conditional branches. The block holds the fetch PC and one epoch bit for each stage that can redirect. Fetch keeps its own copies of both epochs, and decode keeps its own copy of the execute epoch.

Every fetched instruction leaves with two tag bits. As it reaches decode and execute, the block compares those tags with the current epochs. From that comparison it decides whether the instruction is live and whether its misprediction report may move the PC. An instruction with a stale tag is not removed from the pipeline. It travels on marked not-live, and downstream logic gives it no architectural effect.

An execute correction bypasses straight to the fetch port, together with its new epoch, in the cycle it is reported. A decode correction takes effect from the next cycle. When no correction is taken, fetch steps the PC by one instruction width whenever it is allowed to advance.

Top module: `epoch_redirect_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `fetch_pc` equals the RESET_PC parameter and both fetch tags are 0.
- R2: With no redirect taken, `fetch_pc` rises by INSTR_BYTES (default 4) after each clock edge at which `fetch_en` is 1. It holds when `fetch_en` is 0.
- R3: `exe_live` is 1 exactly when `exe_valid` is 1 and `exe_etag` equals the current execute epoch. A poisoned execute instruction never produces `exe_redirect_ok`, whatever `exe_mispredict` says.
- R4: A live execute misprediction asserts `exe_redirect_ok`. In the same cycle, `fetch_pc` shows `exe_target` and `fetch_exe_tag` shows the inverted execute epoch. After the edge, the PC is `exe_target`+INSTR_BYTES if `fetch_en` is 1, and `exe_target` otherwise.
- R5: A live decode misprediction with no execute redirect asserts `dec_redirect_ok`. After the edge, `fetch_pc` is `dec_target` regardless of `fetch_en`, and `fetch_dec_tag` is inverted.
- R6: A decode instruction whose `dec_dtag` differs from the current decode epoch is not live and cannot redirect.
- R7: After an execute redirect, a decode instruction that still carries the old execute epoch in `dec_etag` is not live and cannot redirect.
- R8: When execute and decode both report a live misprediction in the same cycle, execute wins. `dec_redirect_ok` and `dec_live` stay 0, and the decode epoch does not change.
- R9: When decode redirects and execute redirects on an older instruction in the next cycle, fetch ends on the execute target and the execute tag is inverted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_en | input | 1 | Fetch may advance to the next sequential PC |
| fetch_pc | output | PC_W | Address fetched this cycle |
| fetch_dec_tag | output | 1 | Decode-epoch tag for the instruction fetched this cycle |
| fetch_exe_tag | output | 1 | Execute-epoch tag for the instruction fetched this cycle |
| dec_valid | input | 1 | Decode stage holds an instruction |
| dec_dtag | input | 1 | Decode-epoch tag of that instruction |
| dec_etag | input | 1 | Execute-epoch tag of that instruction |
| dec_mispredict | input | 1 | Decode found the predicted next PC wrong |
| dec_target | input | PC_W | Corrected PC from decode |
| dec_live | output | 1 | Decode instruction is on the correct path |
| dec_redirect_ok | output | 1 | Decode redirect accepted |
| exe_valid | input | 1 | Execute stage holds an instruction |
| exe_etag | input | 1 | Execute-epoch tag of that instruction |
| exe_mispredict | input | 1 | Execute found the predicted next PC wrong |
| exe_target | input | PC_W | Corrected PC from execute |
| exe_live | output | 1 | Execute instruction is not poisoned |
| exe_redirect_ok | output | 1 | Execute redirect accepted |

## Verification
Two corrections can land in the same cycle: a live decode misprediction and a live execute misprediction. The bench drives both with different targets on one cycle. It then expects the execute target on `fetch_pc` in that cycle, no decode acceptance, and an unchanged decode tag. The two orderings are also covered. A decode redirect followed one cycle later by an execute redirect must leave fetch on the execute target. An execute redirect followed by a decode instruction carrying the old execute tag must not move the PC.

// File: rtl/epoch_redirect_pkg.sv
package epoch_redirect_pkg;

    typedef enum logic [1:0] {
        REDIR_NONE = 2'd0,
        REDIR_DEC  = 2'd1,
        REDIR_EXE  = 2'd2
    } redir_src_e;

    // owner epochs plus the local copies held by fetch and decode
    typedef struct packed {
        logic dec_own;
        logic exe_own;
        logic fch_dec;
        logic fch_exe;
        logic dcd_exe;
    } epoch_set_t;

endpackage

// File: rtl/redirect_arbiter.sv
module redirect_arbiter
    import epoch_redirect_pkg::*;
(
    input  epoch_set_t st,
    input  logic       dec_valid,
    input  logic       dec_dtag,
    input  logic       dec_etag,
    input  logic       dec_mispredict,
    input  logic       exe_valid,
    input  logic       exe_etag,
    input  logic       exe_mispredict,
    output logic       dec_live,
    output logic       exe_live,
    output redir_src_e src
);

    logic exe_take;

    always_comb begin
        exe_live = exe_valid && (exe_etag == st.exe_own);
        exe_take = exe_live && exe_mispredict;
        // the decode slot is younger than execute: an execute redirect kills it
        dec_live = dec_valid && (dec_dtag == st.dec_own)
                   && (dec_etag == st.dcd_exe) && !exe_take;
        if (exe_take) begin
            src = REDIR_EXE;
        end else if (dec_live && dec_mispredict) begin
            src = REDIR_DEC;
        end else begin
            src = REDIR_NONE;
        end
    end

endmodule

// File: rtl/epoch_state.sv
module epoch_state
    import epoch_redirect_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  redir_src_e src,
    output epoch_set_t st_q,
    output epoch_set_t st_d
);

    always_comb begin
        st_d = st_q;
        case (src)
            REDIR_EXE: begin
                st_d.exe_own = ~st_q.exe_own;
                st_d.fch_exe = ~st_q.fch_exe;
                st_d.dcd_exe = ~st_q.dcd_exe;
            end
            REDIR_DEC: begin
                st_d.dec_own = ~st_q.dec_own;
                st_d.fch_dec = ~st_q.fch_dec;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/fetch_pc_unit.sv
module fetch_pc_unit
    import epoch_redirect_pkg::*;
#(
    parameter int          PC_W        = 32,
    parameter logic [PC_W-1:0] RESET_PC = '0,
    parameter int          INSTR_BYTES = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fetch_en,
    input  redir_src_e      src,
    input  logic [PC_W-1:0] dec_target,
    input  logic [PC_W-1:0] exe_target,
    output logic [PC_W-1:0] fetch_pc
);

    localparam logic [PC_W-1:0] STEP = PC_W'(INSTR_BYTES);

    typedef struct packed {
        logic [PC_W-1:0] pc;
    } pc_state_t;

    pc_state_t pc_d, pc_q;

    always_comb begin
        pc_d     = pc_q;
        fetch_pc = pc_q;
        case (src)
            REDIR_EXE: begin
                fetch_pc = exe_target;
                pc_d.pc  = fetch_en ? exe_target + STEP : exe_target;
            end
            REDIR_DEC: begin
                pc_d.pc = dec_target;
            end
            default: begin
                if (fetch_en) pc_d.pc = pc_q.pc + STEP;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q.pc <= RESET_PC;
        end else begin
            pc_q <= pc_d;
        end
    end

endmodule

// File: rtl/epoch_redirect_ctrl.sv
module epoch_redirect_ctrl
    import epoch_redirect_pkg::*;
#(
    parameter int              PC_W        = 32,
    parameter logic [PC_W-1:0] RESET_PC    = 32'h0000_1000,
    parameter int              INSTR_BYTES = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fetch_en,
    output logic [PC_W-1:0] fetch_pc,
    output logic            fetch_dec_tag,
    output logic            fetch_exe_tag,
    input  logic            dec_valid,
    input  logic            dec_dtag,
    input  logic            dec_etag,
    input  logic            dec_mispredict,
    input  logic [PC_W-1:0] dec_target,
    output logic            dec_live,
    output logic            dec_redirect_ok,
    input  logic            exe_valid,
    input  logic            exe_etag,
    input  logic            exe_mispredict,
    input  logic [PC_W-1:0] exe_target,
    output logic            exe_live,
    output logic            exe_redirect_ok
);

    redir_src_e src;
    epoch_set_t st_q, st_d;

    redirect_arbiter u_arb (
        .st             (st_q),
        .dec_valid      (dec_valid),
        .dec_dtag       (dec_dtag),
        .dec_etag       (dec_etag),
        .dec_mispredict (dec_mispredict),
        .exe_valid      (exe_valid),
        .exe_etag       (exe_etag),
        .exe_mispredict (exe_mispredict),
        .dec_live       (dec_live),
        .exe_live       (exe_live),
        .src            (src)
    );

    epoch_state u_epochs (
        .clk   (clk),
        .rst_n (rst_n),
        .src   (src),
        .st_q  (st_q),
        .st_d  (st_d)
    );

    fetch_pc_unit #(
        .PC_W        (PC_W),
        .RESET_PC    (RESET_PC),
        .INSTR_BYTES (INSTR_BYTES)
    ) u_pc (
        .clk        (clk),
        .rst_n      (rst_n),
        .fetch_en   (fetch_en),
        .src        (src),
        .dec_target (dec_target),
        .exe_target (exe_target),
        .fetch_pc   (fetch_pc)
    );

    always_comb begin
        dec_redirect_ok = (src == REDIR_DEC);
        exe_redirect_ok = (src == REDIR_EXE);
        fetch_dec_tag   = st_q.fch_dec;
        // execute epoch bypasses to fetch in the redirect cycle
        fetch_exe_tag   = exe_redirect_ok ? st_d.fch_exe : st_q.fch_exe;
    end

endmodule

// File: rtl/epoch_redirect_chk.sv
module epoch_redirect_chk #(
    parameter int PC_W        = 32,
    parameter int INSTR_BYTES = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            fetch_en,
    input logic [PC_W-1:0] fetch_pc,
    input logic            fetch_dec_tag,
    input logic            fetch_exe_tag,
    input logic            dec_valid,
    input logic            dec_mispredict,
    input logic [PC_W-1:0] dec_target,
    input logic            dec_live,
    input logic            dec_redirect_ok,
    input logic            exe_valid,
    input logic            exe_mispredict,
    input logic [PC_W-1:0] exe_target,
    input logic            exe_live,
    input logic            exe_redirect_ok
);

    assert_exe_needs_live_R3: assert property (@(posedge clk) disable iff (!rst_n)
        exe_redirect_ok |-> (exe_live && exe_valid && exe_mispredict));

    assert_exe_bypass_pc_R4: assert property (@(posedge clk) disable iff (!rst_n)
        exe_redirect_ok |-> (fetch_pc == exe_target));

    assert_exe_tag_settles_R4: assert property (@(posedge clk) disable iff (!rst_n)
        exe_redirect_ok |=> (fetch_exe_tag == $past(fetch_exe_tag)));

    assert_dec_pc_next_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dec_redirect_ok |=> (exe_redirect_ok || fetch_pc == $past(dec_target)));

    assert_dec_tag_flip_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dec_redirect_ok |=> (fetch_dec_tag != $past(fetch_dec_tag)));

    assert_exe_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        exe_redirect_ok |-> (!dec_redirect_ok && !dec_live));

    assert_seq_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_en && !exe_redirect_ok && !dec_redirect_ok) |=>
        (exe_redirect_ok || fetch_pc == $past(fetch_pc) + PC_W'(INSTR_BYTES)));

    assert_dec_needs_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dec_redirect_ok |-> (dec_valid && dec_mispredict));

endmodule

bind epoch_redirect_ctrl epoch_redirect_chk #(
    .PC_W        (PC_W),
    .INSTR_BYTES (INSTR_BYTES)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .fetch_en        (fetch_en),
    .fetch_pc        (fetch_pc),
    .fetch_dec_tag   (fetch_dec_tag),
    .fetch_exe_tag   (fetch_exe_tag),
    .dec_valid       (dec_valid),
    .dec_mispredict  (dec_mispredict),
    .dec_target      (dec_target),
    .dec_live        (dec_live),
    .dec_redirect_ok (dec_redirect_ok),
    .exe_valid       (exe_valid),
    .exe_mispredict  (exe_mispredict),
    .exe_target      (exe_target),
    .exe_live        (exe_live),
    .exe_redirect_ok (exe_redirect_ok)
);

// File: tb/epoch_redirect_ctrl_bench.sv
module epoch_redirect_ctrl_bench;

    localparam int          PC_W     = 32;
    localparam logic [31:0] RST_PC   = 32'h0000_1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_en = 1'b0;
    logic [31:0] fetch_pc;
    logic        fetch_dec_tag, fetch_exe_tag;
    logic        dec_valid = 1'b0, dec_dtag = 1'b0, dec_etag = 1'b0, dec_mispredict = 1'b0;
    logic [31:0] dec_target = '0;
    logic        dec_live, dec_redirect_ok;
    logic        exe_valid = 1'b0, exe_etag = 1'b0, exe_mispredict = 1'b0;
    logic [31:0] exe_target = '0;
    logic        exe_live, exe_redirect_ok;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    epoch_redirect_ctrl #(.PC_W(PC_W), .RESET_PC(RST_PC), .INSTR_BYTES(4)) u_epoch_redirect_ctrl (
        .clk(clk), .rst_n(rst_n), .fetch_en(fetch_en), .fetch_pc(fetch_pc),
        .fetch_dec_tag(fetch_dec_tag), .fetch_exe_tag(fetch_exe_tag),
        .dec_valid(dec_valid), .dec_dtag(dec_dtag), .dec_etag(dec_etag),
        .dec_mispredict(dec_mispredict), .dec_target(dec_target),
        .dec_live(dec_live), .dec_redirect_ok(dec_redirect_ok),
        .exe_valid(exe_valid), .exe_etag(exe_etag), .exe_mispredict(exe_mispredict),
        .exe_target(exe_target), .exe_live(exe_live), .exe_redirect_ok(exe_redirect_ok)
    );

    typedef struct packed {
        logic        fen;
        logic        ev;
        logic        et;
        logic        em;
        logic [31:0] etgt;
        logic        dv;
        logic        ddt;
        logic        det;
        logic        dm;
        logic [31:0] dtgt;
        logic [31:0] xpc;
        logic        xtd;
        logic        xte;
        logic        xeok;
        logic        xdok;
        logic        xdl;
        logic        xel;
        logic [3:0]  req;
    } vec_t;

    // fen ev et em etgt | dv ddt det dm dtgt | pc td te eok dok dlive elive | req
    localparam vec_t VECS [12] = '{
        '{1'b1,1'b0,1'b0,1'b0,32'h0,    1'b0,1'b0,1'b0,1'b0,32'h0,    32'h1000,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,4'd2}, // R2 step
        '{1'b0,1'b0,1'b0,1'b0,32'h0,    1'b0,1'b0,1'b0,1'b0,32'h0,    32'h1004,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,4'd2}, // R2 hold
        '{1'b1,1'b0,1'b0,1'b0,32'h0,    1'b1,1'b0,1'b0,1'b1,32'h2000, 32'h1004,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,4'd5}, // R5 decode redirect
        '{1'b1,1'b0,1'b0,1'b0,32'h0,    1'b1,1'b0,1'b0,1'b1,32'h3000, 32'h2000,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,4'd6}, // R6 stale dtag
        '{1'b1,1'b1,1'b0,1'b1,32'h4000, 1'b1,1'b1,1'b0,1'b1,32'h5000, 32'h4000,1'b1,1'b1,1'b1,1'b0,1'b0,1'b1,4'd8}, // R8 same cycle
        '{1'b1,1'b0,1'b0,1'b0,32'h0,    1'b1,1'b1,1'b0,1'b1,32'h6000, 32'h4004,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,4'd7}, // R7 stale etag
        '{1'b1,1'b1,1'b0,1'b1,32'h7000, 1'b0,1'b0,1'b0,1'b0,32'h0,    32'h4008,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,4'd3}, // R3 poisoned
        '{1'b1,1'b0,1'b0,1'b0,32'h0,    1'b1,1'b1,1'b1,1'b1,32'h8000, 32'h400C,1'b1,1'b1,1'b0,1'b1,1'b1,1'b0,4'd5}, // R5 again
        '{1'b1,1'b1,1'b1,1'b1,32'h9000, 1'b0,1'b0,1'b0,1'b0,32'h0,    32'h9000,1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,4'd9}, // R9 dec then exe
        '{1'b0,1'b1,1'b0,1'b0,32'h0,    1'b0,1'b0,1'b0,1'b0,32'h0,    32'h9004,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,4'd3}, // R3 live, no misp
        '{1'b0,1'b1,1'b0,1'b1,32'hA000, 1'b0,1'b0,1'b0,1'b0,32'h0,    32'hA000,1'b0,1'b1,1'b1,1'b0,1'b0,1'b1,4'd4}, // R4 bypass
        '{1'b1,1'b0,1'b0,1'b0,32'h0,    1'b0,1'b0,1'b0,1'b0,32'h0,    32'hA000,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,4'd4}  // R4 no step when stalled
    };

    task automatic check(input string what, input int req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        fetch_en = 1'b0; dec_valid = 1'b0; dec_dtag = 1'b0; dec_etag = 1'b0;
        dec_mispredict = 1'b0; dec_target = '0; exe_valid = 1'b0; exe_etag = 1'b0;
        exe_mispredict = 1'b0; exe_target = '0;
    endtask

    initial begin
        idle_inputs();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        // R1 while in reset
        check("pc in reset", 1, fetch_pc, RST_PC);
        check("tags in reset", 1, {30'd0, fetch_dec_tag, fetch_exe_tag}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check("pc after reset", 1, fetch_pc, RST_PC);

        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            fetch_en = VECS[i].fen;
            exe_valid = VECS[i].ev; exe_etag = VECS[i].et;
            exe_mispredict = VECS[i].em; exe_target = VECS[i].etgt;
            dec_valid = VECS[i].dv; dec_dtag = VECS[i].ddt; dec_etag = VECS[i].det;
            dec_mispredict = VECS[i].dm; dec_target = VECS[i].dtgt;
            #1;
            check($sformatf("row %0d fetch_pc", i), int'(VECS[i].req), fetch_pc, VECS[i].xpc);
            check($sformatf("row %0d fetch tags", i), int'(VECS[i].req),
                  {30'd0, fetch_dec_tag, fetch_exe_tag}, {30'd0, VECS[i].xtd, VECS[i].xte});
            check($sformatf("row %0d redirect oks", i), int'(VECS[i].req),
                  {30'd0, exe_redirect_ok, dec_redirect_ok}, {30'd0, VECS[i].xeok, VECS[i].xdok});
            check($sformatf("row %0d live flags", i), int'(VECS[i].req),
                  {30'd0, dec_live, exe_live}, {30'd0, VECS[i].xdl, VECS[i].xel});
        end

        // R1: reset in mid-run restores PC and clears epochs
        @(negedge clk);
        idle_inputs();
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check("pc after mid-run reset", 1, fetch_pc, RST_PC);
        check("tags after mid-run reset", 1, {30'd0, fetch_dec_tag, fetch_exe_tag}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        // R6: decode tag 1 is stale against a cleared decode epoch
        dec_valid = 1'b1; dec_dtag = 1'b1; dec_mispredict = 1'b1; dec_target = 32'hB000;
        #1;
        check("stale dtag after reset", 6, {31'd0, dec_redirect_ok}, 32'd0);
        @(negedge clk);
        idle_inputs();
        #1;
        check("pc unmoved by dropped decode", 6, fetch_pc, RST_PC);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule